// File: doc/BRIEF.md
# Power-Management Register Window with System Control Interrupt

This block places a small power-management register window in a 16-bit I/O space and raises a level-sensitive system control interrupt (SCI) from a set of event status flags and their enables. The window base comes from a 32-bit configuration input. Its low six bits are ignored, so the window is always aligned to 64 bytes. A separate configuration byte turns the window on and off. Inside the window sit a 16-bit event status register, a 16-bit event enable register and a free-running timer that software can read.

Status flags are set by three external event pulses (global lock, power button, RTC alarm) and by the timer's most significant bit changing state. Software clears a flag by writing a one to it. The SCI output is the OR of every flag whose enable is set, taken over exactly four sources. Because it is formed combinationally from the two registers, it drops in the same cycle that a flag is cleared or its enable is removed.

Top module: `pm_sci_window`

## Requirements
- R1: After reset, the status flags and the enable register are zero, the timer is zero and `sci` is low.
- R2: When the window is on, `ioHit` is high for exactly the 64 addresses `(cfgBase[15:0] & 16'hFFC0)` through that value plus 63, and low for all other addresses.
- R3: While `cfgCtl[0]` is 0, the window is off. `ioHit` stays low, writes change nothing and `ioRdData` reads 0. The other bits of `cfgCtl` have no effect.
- R4: The register map sits at these byte offsets within the window: 0x00 status, 0x02 enable, 0x08 timer. Reads return the value zero-extended on the 32-bit `ioRdData`. Any other offset in the window reads 0.
- R5: The status word uses these bit positions: timer 0, global lock 5, power button 8, RTC alarm 10. All other bits read 0. A one-cycle pulse on `evGlobalLock`, `evPowerBtn` or `evRtcAlarm` sets its flag at the next clock edge, and the flag stays set.
- R6: A write to offset 0x00 clears each flag whose data bit (`ioWrData[15:0]`) is 1 and leaves the others unchanged. If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R7: The enable register holds all 16 bits written at offset 0x02 and reads them back unchanged.
- R8: `sci` is high exactly when some flag among bits 0, 5, 8 and 10 is set and the enable bit at the same position is set. Enable bits at other positions have no effect. `sci` falls immediately after the clock edge that clears the flag or the enable.
- R9: The timer is a `TMR_W`-bit counter. It increments by one on every clock and wraps at its width. It reads at offset 0x08.
- R10: The timer flag (bit 0) sets on the clock edge at which the timer MSB changes state, in either direction. This happens only while enable bit 0 is set and the flag is clear. With enable bit 0 clear, MSB changes leave the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBase | input | 32 | Window base configuration dword; bits 15:6 are used |
| cfgCtl | input | 8 | Window control byte; bit 0 turns the window on |
| ioAddr | input | 16 | I/O byte address |
| ioWrEn | input | 1 | I/O write strobe |
| ioRdEn | input | 1 | I/O read strobe |
| ioWrData | input | 32 | Write data; bits 15:0 are used |
| ioRdData | output | 32 | Read data, combinational, zero when not hit |
| ioHit | output | 1 | Address falls inside the active window |
| evGlobalLock | input | 1 | Global-lock event pulse |
| evPowerBtn | input | 1 | Power-button event pulse |
| evRtcAlarm | input | 1 | RTC alarm event pulse |
| sci | output | 1 | Level system control interrupt |

## Verification
The in-line properties check several rules on every cycle:
- A flag only falls after a write whose data bit at its position was one.
- The enable register only changes after a write to it.
- `sci` only falls after a register write.
- The timer advances by exactly one per clock.
- The timer flag only rises while its enable was set.
- An off window returns zero data.

Other behaviours need the directed scenarios to show them:
- The exact window boundaries.
- The register layout and bit positions.
- The set-beats-clear collision.
- The exact edge at which the timer MSB changes state and sets the flag.
- Enable bits outside the four sources leaving `sci` low.

// File: rtl/pm_sci_pkg.sv
`timescale 1ns/1ps
package pm_sci_pkg;
  localparam int REG_W    = 16;
  localparam int BIT_TMR  = 0;
  localparam int BIT_LOCK = 5;
  localparam int BIT_PWR  = 8;
  localparam int BIT_RTC  = 10;
  localparam int NSRC     = 4;
  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_LOCK) | (1 << BIT_PWR) | (1 << BIT_RTC));

  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_EN  = 6'h02;
  localparam logic [5:0] OFS_TMR = 6'h08;

  // strobes from the decode control to the register datapath
  typedef struct packed {
    logic hit;
    logic wrSts;
    logic wrEn;
    logic rdSts;
    logic rdEn;
    logic rdTmr;
  } pmStrobe_t;

  function automatic int srcPos(input int k);
    case (k)
      0:       return BIT_TMR;
      1:       return BIT_LOCK;
      2:       return BIT_PWR;
      default: return BIT_RTC;
    endcase
  endfunction
endpackage

// File: rtl/pm_win_ctl.sv
`timescale 1ns/1ps
module pm_win_ctl
  import pm_sci_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 64
) (
  input  logic [31:0]       cfgBase,
  input  logic [7:0]        cfgCtl,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output pmStrobe_t         strobe
);
  localparam int OFS_W = $clog2(WIN_BYTES);

  logic             winOn;
  logic             baseMatch;
  logic [OFS_W-1:0] ofs;
  logic             unusedCfg;

  assign winOn     = cfgCtl[0];
  // comparing only the bits above the offset aligns the base to WIN_BYTES
  assign baseMatch = (ioAddr[ADDR_W-1:OFS_W] == cfgBase[ADDR_W-1:OFS_W]);
  assign ofs       = ioAddr[OFS_W-1:0];
  assign unusedCfg = ^{cfgBase[31:ADDR_W], cfgBase[OFS_W-1:0], cfgCtl[7:1]};

  always_comb begin
    strobe     = '0;
    strobe.hit = winOn && baseMatch;
    if (strobe.hit) begin
      strobe.wrSts = ioWrEn && (ofs == OFS_W'(OFS_STS));
      strobe.wrEn  = ioWrEn && (ofs == OFS_W'(OFS_EN));
      strobe.rdSts = ioRdEn && (ofs == OFS_W'(OFS_STS));
      strobe.rdEn  = ioRdEn && (ofs == OFS_W'(OFS_EN));
      strobe.rdTmr = ioRdEn && (ofs == OFS_W'(OFS_TMR));
    end
  end
endmodule

// File: rtl/pm_tmr.sv
`timescale 1ns/1ps
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [TMR_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= count + TMR_W'(1);
  end

  // high in the cycle before the MSB changes state
  assign wrap = &count[TMR_W-2:0];

  p_tmr_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (count == $past(count) + TMR_W'(1)));
endmodule

// File: rtl/pm_regs_dp.sv
`timescale 1ns/1ps
module pm_regs_dp
  import pm_sci_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evLock,
  input  logic              evPwr,
  input  logic              evRtc,
  output logic [DATA_W-1:0] rdData,
  output logic              sci
);
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] stsWord;
  logic [NSRC-1:0]  stsBit;
  logic [NSRC-1:0]  srcSet;
  logic [TMR_W-1:0] tmrVal;
  logic             tmrWrap;
  logic             unusedWr;

  assign unusedWr = ^wrData[DATA_W-1:REG_W];

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rstN  (rstN),
    .count (tmrVal),
    .wrap  (tmrWrap)
  );

  // timer flag is armed only while enabled and not already pending
  assign srcSet[0] = tmrWrap && enReg[BIT_TMR] && !stsBit[0];
  assign srcSet[1] = evLock;
  assign srcSet[2] = evPwr;
  assign srcSet[3] = evRtc;

  for (genvar k = 0; k < NSRC; k++) begin : g_sts
    localparam int POS = srcPos(k);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            stsBit[k] <= 1'b0;
      else if (srcSet[k])                   stsBit[k] <= 1'b1;
      else if (strobe.wrSts && wrData[POS]) stsBit[k] <= 1'b0;
    end

    p_sts_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(stsBit[k]) |-> $past(strobe.wrSts && wrData[POS]));
  end

  always_comb begin
    stsWord = '0;
    for (int k = 0; k < NSRC; k++) stsWord[srcPos(k)] = stsBit[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enReg <= '0;
    else if (strobe.wrEn) enReg <= wrData[REG_W-1:0];
  end

  assign sci = |(stsWord & enReg & SCI_MASK);

  always_comb begin
    rdData = '0;
    if (strobe.rdSts)      rdData = DATA_W'(stsWord);
    else if (strobe.rdEn)  rdData = DATA_W'(enReg);
    else if (strobe.rdTmr) rdData = DATA_W'(tmrVal);
  end

  p_en_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enReg) |-> $past(strobe.wrEn));

  p_sci_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sci) |-> $past(strobe.wrSts || strobe.wrEn));

  p_tmr_arm_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsBit[0]) |-> $past(enReg[BIT_TMR]));
endmodule

// File: rtl/pm_sci_window.sv
`timescale 1ns/1ps
module pm_sci_window
  import pm_sci_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WIN_BYTES = 64,
  parameter int TMR_W     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgBase,
  input  logic [7:0]        cfgCtl,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              ioHit,
  input  logic              evGlobalLock,
  input  logic              evPowerBtn,
  input  logic              evRtcAlarm,
  output logic              sci
);
  pmStrobe_t strobe;

  pm_win_ctl #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_ctl (
    .cfgBase (cfgBase),
    .cfgCtl  (cfgCtl),
    .ioAddr  (ioAddr),
    .ioWrEn  (ioWrEn),
    .ioRdEn  (ioRdEn),
    .strobe  (strobe)
  );

  pm_regs_dp #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (ioWrData),
    .evLock (evGlobalLock),
    .evPwr  (evPowerBtn),
    .evRtc  (evRtcAlarm),
    .rdData (ioRdData),
    .sci    (sci)
  );

  assign ioHit = strobe.hit;

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCtl[0] |-> (ioRdData == '0 && !ioHit));
endmodule

// File: tb/test_pm_sci_window.sv
`timescale 1ns/1ps
module test_pm_sci_window;
  localparam int TW = 8;
  localparam logic [15:0] BASE = 16'h5640;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgBase = 32'h0;
  logic [7:0]  cfgCtl = 8'h0;
  logic [15:0] ioAddr = 16'h0;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [31:0] ioWrData = 32'h0;
  logic [31:0] ioRdData;
  logic        ioHit;
  logic        evGlobalLock = 1'b0;
  logic        evPowerBtn = 1'b0;
  logic        evRtcAlarm = 1'b0;
  logic        sci;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_sci_window #(.TMR_W(TW)) i_pm_sci_window (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgCtl(cfgCtl),
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .ioHit(ioHit), .evGlobalLock(evGlobalLock),
    .evPowerBtn(evPowerBtn), .evRtcAlarm(evRtcAlarm), .sci(sci)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRd(input logic [15:0] a, output logic [31:0] d, output logic h);
    ioAddr = a; ioRdEn = 1'b1;
    #1 d = ioRdData; h = ioHit;
    ioRdEn = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      1: evGlobalLock = 1'b1;
      2: evPowerBtn = 1'b1;
      default: evRtcAlarm = 1'b1;
    endcase
    @(negedge clk);
    evGlobalLock = 1'b0; evPowerBtn = 1'b0; evRtcAlarm = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic h;
    repeat (3) @(negedge clk);
    chk("R1 sci in reset", {31'b0, sci}, 32'h0);
    ioRd(BASE, d, h);
    chk("R1 no hit in reset", {31'b0, h}, 32'h0);
    rstN = 1'b1;
    cfgBase = 32'h1234_5678;
    cfgCtl = 8'h01;
    @(negedge clk);
    ioRd(BASE + 16'h0, d, h);
    chk("R1 status zero", d, 32'h0);
    ioRd(BASE + 16'h2, d, h);
    chk("R1 enable zero", d, 32'h0);
    ioRd(BASE + 16'h8, d, h);
    chk("R1 timer near zero", {31'b0, (d < 32'd4)}, 32'h1);
  endtask

  task automatic t_window;
    logic [31:0] d; logic h;
    @(negedge clk);
    ioRd(BASE, d, h);            chk("R2 hit at base", {31'b0, h}, 32'h1);
    ioRd(BASE + 16'd63, d, h);   chk("R2 hit at last byte", {31'b0, h}, 32'h1);
    ioRd(BASE + 16'd64, d, h);   chk("R2 miss above", {31'b0, h}, 32'h0);
    ioRd(BASE - 16'd1, d, h);    chk("R2 miss below", {31'b0, h}, 32'h0);
    ioWr(BASE + 16'd66, 32'h0000_FFFF);
    ioRd(BASE + 16'h2, d, h);    chk("R2 write outside ignored", d, 32'h0);
    cfgCtl = 8'hFE;
    ioRd(BASE + 16'h2, d, h);    chk("R3 off no hit", {31'b0, h}, 32'h0);
    ioWr(BASE + 16'h2, 32'h0000_0120);
    ioRd(BASE + 16'h2, d, h);    chk("R3 off reads zero", d, 32'h0);
    cfgCtl = 8'h01;
    @(negedge clk);
    ioRd(BASE + 16'h2, d, h);    chk("R3 off write ignored", d, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d; logic h;
    ioWr(BASE + 16'h2, 32'hFFFF_A5A5);
    ioRd(BASE + 16'h2, d, h);    chk("R7 enable readback", d, 32'h0000_A5A5);
    ioRd(BASE + 16'h4, d, h);    chk("R4 unmapped offset", d, 32'h0);
    ioRd(BASE + 16'h4, d, h);    chk("R4 unmapped still hit", {31'b0, h}, 32'h1);
    ioWr(BASE + 16'h2, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d; logic h;
    int pos [3] = '{5, 8, 10};
    for (int s = 0; s < 3; s++) begin
      pulse(s + 1);
      ioRd(BASE, d, h);
      chk("R5 flag set at position", d, 32'(1) << pos[s]);
      chk("R8 no sci while disabled", {31'b0, sci}, 32'h0);
      ioWr(BASE + 16'h2, 32'(1) << pos[s]);
      #1 chk("R8 sci on enable", {31'b0, sci}, 32'h1);
      ioWr(BASE + 16'h2, 32'h0);
      #1 chk("R8 sci falls with enable", {31'b0, sci}, 32'h0);
      ioWr(BASE + 16'h2, 32'(1) << pos[s]);
      ioWr(BASE, 32'(1) << pos[s]);
      #1 chk("R8 sci falls with clear", {31'b0, sci}, 32'h0);
      ioRd(BASE, d, h);
      chk("R6 flag cleared", d, 32'h0);
      ioWr(BASE + 16'h2, 32'h0);
    end
  endtask

  task automatic t_w1c;
    logic [31:0] d; logic h;
    pulse(1);
    ioWr(BASE, 32'h0000_FBDF);
    ioRd(BASE, d, h);            chk("R6 zero bit keeps flag", d, 32'h0000_0020);
    @(negedge clk);
    ioAddr = BASE; ioWrData = 32'h20; ioWrEn = 1'b1; evGlobalLock = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0; evGlobalLock = 1'b0;
    ioRd(BASE, d, h);            chk("R6 set beats clear", d, 32'h0000_0020);
    pulse(2); pulse(3);
    ioWr(BASE + 16'h2, 32'h0000_FADE);
    #1 chk("R8 other enables ignored", {31'b0, sci}, 32'h0);
    ioWr(BASE + 16'h2, 32'h0);
    ioWr(BASE, 32'h0000_FFFF);
    ioRd(BASE, d, h);            chk("R6 all cleared", d, 32'h0);
  endtask

  task automatic t_timer;
    logic [31:0] d, v1, v2; logic h;
    @(negedge clk);
    ioRd(BASE + 16'h8, v1, h);
    repeat (10) @(negedge clk);
    ioRd(BASE + 16'h8, v2, h);
    chk("R9 timer advances", (v2 - v1) & 32'hFF, 32'd10);
    // line up far from an MSB change, then arm
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); ioRd(BASE + 16'h8, d, h);
      if (d[TW-2:0] == 7'd1) break;
    end
    ioWr(BASE + 16'h2, 32'h1);
    ioWr(BASE, 32'h1);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); ioRd(BASE + 16'h8, d, h);
      if (d[TW-2:0] == '1) break;
    end
    chk("R10 flag clear before MSB change", {31'b0, sci}, 32'h0);
    @(negedge clk);
    ioRd(BASE + 16'h8, v2, h);
    chk("R9 MSB changed", {31'b0, v2[TW-1]}, {31'b0, ~d[TW-1]});
    ioRd(BASE, v1, h);
    chk("R10 flag set on MSB change", v1, 32'h1);
    chk("R8 timer sci", {31'b0, sci}, 32'h1);
    ioWr(BASE + 16'h2, 32'h0);
    ioWr(BASE, 32'h1);
    repeat (300) @(negedge clk);
    ioRd(BASE, v1, h);
    chk("R10 no flag while disabled", v1, 32'h0);
    chk("R10 no sci while disabled", {31'b0, sci}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_window();
    t_regmap();
    t_events();
    t_w1c();
    t_timer();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errCnt++; chkCnt++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule